// File: doc/BRIEF.md
# Privileged Virtual Segment Decoder

This block sorts each 32-bit virtual address into one of five fixed address windows and decides, from the requester's privilege level and an error-level flag, what happens to the access. Windows that bypass translation produce a physical address at once, by stripping the window base. Windows that need translation forward the virtual address to a TLB lookup port. Accesses the current privilege may not make are reported as address errors, split into a load kind and a store kind.

One request may enter per cycle. The classification, the physical address and the error code are registered and appear, together with a valid strobe and the TLB request, exactly one clock after the request. A core's load/store or fetch pipeline stage would sit in front of it, and the TLB and exception logic behind it.

Top module: `priv_seg_decoder`

## Requirements
- R1: While reset is held and after it is released, before any request, `rsp_valid` and `tlb_req_valid` are 0.
- R2: Each request with `req_valid`=1 yields exactly one response with `rsp_valid`=1 on the next clock edge; no response appears without a request.
- R3: With `req_err_lvl`=0, an address 0x00000000–0x7FFFFFFF is translated in every mode: `rsp_mapped`=1, `tlb_req_valid`=1, `tlb_vaddr` equals the address, `rsp_fault`=00 and `rsp_paddr`=0. When no TLB request is made, `tlb_vaddr` is 0.
- R4: With `req_err_lvl`=1, an address 0x00000000–0x7FFFFFFF is passed through in every mode: `rsp_mapped`=0, `rsp_paddr` equals the address, no TLB request, no fault.
- R5: In kernel mode, an address 0x80000000–0x9FFFFFFF is passed through with `rsp_paddr` = address − 0x80000000.
- R6: In kernel mode, an address 0xA0000000–0xBFFFFFFF is passed through with `rsp_paddr` = address − 0xA0000000.
- R7: An address 0xC0000000–0xDFFFFFFF is translated (as in R3) in kernel and supervisor modes and faults in user mode.
- R8: An address 0xE0000000–0xFFFFFFFF is translated in kernel mode only and faults in supervisor and user modes.
- R9: The two pass-through windows of R5 and R6 fault in supervisor and user modes.
- R10: A fault sets `rsp_fault` to 10 for a store (`req_store`=1) and 01 otherwise, with `rsp_mapped`=0, `rsp_paddr`=0 and no TLB request; 00 means no fault.
- R11: `req_mode` encodes 00 kernel, 01 supervisor, 10 user; 11 behaves exactly as user.
- R12: `req_err_lvl` has no effect on addresses 0x80000000 and above.
- R13: `rsp_seg` reports the window, also on a fault: 0 for 0x0–0x7FFFFFFF, 1 for 0x80–0x9F…, 2 for 0xA0–0xBF…, 3 for 0xC0–0xDF…, 4 for 0xE0–0xFF….

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request strobe |
| req_vaddr | input | VA_W | Virtual address |
| req_store | input | 1 | 1 for a store, 0 for a load or fetch |
| req_mode | input | 2 | Privilege: 00 kernel, 01 supervisor, 10/11 user |
| req_err_lvl | input | 1 | Error-level flag |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_seg | output | 3 | Window code |
| rsp_mapped | output | 1 | Access needs TLB translation |
| rsp_fault | output | 2 | 00 none, 01 load address error, 10 store address error |
| rsp_paddr | output | VA_W | Physical address for pass-through windows, else 0 |
| tlb_req_valid | output | 1 | TLB lookup request |
| tlb_vaddr | output | VA_W | Address forwarded to the TLB, else 0 |

## Verification
The bench builds the block with its default address width of 32 bits, the only width at which the window boundaries are meaningful, so every boundary address (first and last byte of each window) can be driven directly. It sweeps those boundaries across all four mode codes, both error-level values and both access kinds, then runs a stream of pseudo-random addresses with idle gaps and back-to-back requests, which exercises the one-cycle alignment of responses with requests.

// File: rtl/seg_pkg.sv
// Shared types and codes for the privileged segment decoder.
// Assumes a fixed five-window layout selected by the top three address bits.
package seg_pkg;

    typedef enum logic [2:0] {
        SEG_USER   = 3'd0,
        SEG_KDIR0  = 3'd1,
        SEG_KDIR1  = 3'd2,
        SEG_SUPMAP = 3'd3,
        SEG_KMAP   = 3'd4
    } seg_e;

    typedef enum logic [1:0] {
        FLT_NONE  = 2'b00,
        FLT_LOAD  = 2'b01,
        FLT_STORE = 2'b10
    } fault_e;

    localparam logic [1:0] MODE_KERNEL = 2'b00;
    localparam logic [1:0] MODE_SUPER  = 2'b01;

    localparam int SEL_W = 3;

endpackage

// File: rtl/seg_classify.sv
// Window classifier: maps the top address bits to a window code.
// Assumes the selector is the three most significant address bits.
module seg_classify
    import seg_pkg::*;
(
    input  logic [SEL_W-1:0] sel_bits,
    output seg_e             seg
);

    // Decode the selector into a window.
    always_comb begin
        if (!sel_bits[SEL_W-1]) begin
            seg = SEG_USER;
        end else begin
            case (sel_bits[SEL_W-2:0])
                2'b00:   seg = SEG_KDIR0;
                2'b01:   seg = SEG_KDIR1;
                2'b10:   seg = SEG_SUPMAP;
                default: seg = SEG_KMAP;
            endcase
        end
    end

endmodule

// File: rtl/seg_access_check.sv
// Privilege checker: decides whether the window is allowed in the current
// mode, whether it is translated, and which fault code applies.
// Assumes mode code 11 is user.
module seg_access_check
    import seg_pkg::*;
(
    input  seg_e        seg,
    input  logic [1:0]  mode,
    input  logic        err_lvl,
    input  logic        is_store,
    output logic        allowed,
    output logic        mapped,
    output fault_e      fault
);

    logic is_kern;
    logic is_sup;

    // Decode the privilege level.
    always_comb begin
        is_kern = (mode == MODE_KERNEL);
        is_sup  = (mode == MODE_SUPER);
    end

    // Per-window access rights.
    always_comb begin
        case (seg)
            SEG_USER:   allowed = 1'b1;
            SEG_SUPMAP: allowed = is_kern | is_sup;
            default:    allowed = is_kern;
        endcase
    end

    // Translation need and fault code.
    always_comb begin
        mapped = 1'b0;
        fault  = FLT_NONE;
        if (!allowed) begin
            fault = is_store ? FLT_STORE : FLT_LOAD;
        end else begin
            case (seg)
                SEG_USER:   mapped = !err_lvl;
                SEG_SUPMAP: mapped = 1'b1;
                SEG_KMAP:   mapped = 1'b1;
                default:    mapped = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/seg_xlate.sv
// Direct translator: forms the physical address for pass-through windows.
// Assumes the caller gates it with an allowed-and-unmapped flag.
module seg_xlate
    import seg_pkg::*;
#(
    parameter int VA_W = 32
) (
    input  seg_e            seg,
    input  logic [VA_W-1:0] vaddr,
    input  logic            direct,
    output logic [VA_W-1:0] paddr
);

    localparam int          OFS_W = VA_W - SEL_W;
    localparam logic [VA_W-1:0] BASE0 = {3'b100, {OFS_W{1'b0}}};
    localparam logic [VA_W-1:0] BASE1 = {3'b101, {OFS_W{1'b0}}};

    // Strip the window base for pass-through accesses.
    always_comb begin
        paddr = '0;
        if (direct) begin
            case (seg)
                SEG_USER:  paddr = vaddr;
                SEG_KDIR0: paddr = vaddr - BASE0;
                SEG_KDIR1: paddr = vaddr - BASE1;
                default:   paddr = '0;
            endcase
        end
    end

endmodule

// File: rtl/priv_seg_decoder.sv
// Privileged virtual segment decoder top level.
// Classifies a request, checks privilege, translates pass-through windows
// and registers the result one cycle later with a TLB request for mapped
// windows. Assumes one request per cycle and no back-pressure.
module priv_seg_decoder
    import seg_pkg::*;
#(
    parameter int VA_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [VA_W-1:0] req_vaddr,
    input  logic            req_store,
    input  logic [1:0]      req_mode,
    input  logic            req_err_lvl,
    output logic            rsp_valid,
    output logic [2:0]      rsp_seg,
    output logic            rsp_mapped,
    output logic [1:0]      rsp_fault,
    output logic [VA_W-1:0] rsp_paddr,
    output logic            tlb_req_valid,
    output logic [VA_W-1:0] tlb_vaddr
);

    seg_e            seg_c;
    logic            allowed_c;
    logic            mapped_c;
    fault_e          fault_c;
    logic [VA_W-1:0] paddr_c;
    logic            direct_c;

    seg_classify u_classify (
        .sel_bits (req_vaddr[VA_W-1 -: SEL_W]),
        .seg      (seg_c)
    );

    seg_access_check u_check (
        .seg      (seg_c),
        .mode     (req_mode),
        .err_lvl  (req_err_lvl),
        .is_store (req_store),
        .allowed  (allowed_c),
        .mapped   (mapped_c),
        .fault    (fault_c)
    );

    // Pass-through only when allowed and not translated.
    always_comb direct_c = allowed_c & !mapped_c;

    seg_xlate #(.VA_W(VA_W)) u_xlate (
        .seg    (seg_c),
        .vaddr  (req_vaddr),
        .direct (direct_c),
        .paddr  (paddr_c)
    );

    // Output register: one-cycle response, cleared when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !req_valid) begin
            rsp_valid     <= 1'b0;
            rsp_seg       <= '0;
            rsp_mapped    <= 1'b0;
            rsp_fault     <= '0;
            rsp_paddr     <= '0;
            tlb_req_valid <= 1'b0;
            tlb_vaddr     <= '0;
        end else begin
            rsp_valid     <= 1'b1;
            rsp_seg       <= seg_c;
            rsp_mapped    <= mapped_c;
            rsp_fault     <= fault_c;
            rsp_paddr     <= paddr_c;
            tlb_req_valid <= mapped_c;
            tlb_vaddr     <= mapped_c ? req_vaddr : '0;
        end
    end

endmodule

// File: rtl/seg_decoder_checker.sv
// Property checker for the segment decoder, attached by bind.
// Assumes req_valid is held low while reset is asserted.
module seg_decoder_checker #(
    parameter int VA_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic [VA_W-1:0] req_vaddr,
    input logic            req_store,
    input logic [1:0]      req_mode,
    input logic            req_err_lvl,
    input logic            rsp_valid,
    input logic [2:0]      rsp_seg,
    input logic            rsp_mapped,
    input logic [1:0]      rsp_fault,
    input logic [VA_W-1:0] rsp_paddr,
    input logic            tlb_req_valid,
    input logic [VA_W-1:0] tlb_vaddr
);

    // R2: a response follows each request by exactly one cycle
    p_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid == $past(req_valid));

    // R3: untranslated-error-free user access goes to the TLB with its address
    p_user_tlb_r3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_vaddr[VA_W-1] && !req_err_lvl
        |=> tlb_req_valid && tlb_vaddr == $past(req_vaddr) && rsp_seg == 3'd0);

    // R4: error level makes the user window identity
    p_user_erl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_vaddr[VA_W-1] && req_err_lvl
        |=> !tlb_req_valid && rsp_paddr == $past(req_vaddr));

    // R5: kernel pass-through strips the first base
    p_kdir0_r5: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_vaddr[VA_W-1 -: 3] == 3'b100 && req_mode == 2'b00
        |=> rsp_paddr == {3'b000, $past(req_vaddr[VA_W-4:0])});

    // R8: top window faults outside kernel mode
    p_kmap_user_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_vaddr[VA_W-1 -: 3] == 3'b111 && req_mode != 2'b00
        |=> rsp_fault != 2'b00);

    // R10: a store fault is reported with the store code
    p_store_code_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_store && req_vaddr[VA_W-1] && req_mode[1]
        |=> rsp_fault == 2'b10);

    // R10: a faulting response never translates or requests the TLB
    p_fault_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_fault != 2'b00 |-> !rsp_mapped && !tlb_req_valid && rsp_paddr == '0);

    // R1: no TLB request without a response
    p_tlb_needs_rsp_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_req_valid |-> rsp_valid);

endmodule

bind priv_seg_decoder seg_decoder_checker #(.VA_W(VA_W)) u_seg_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_vaddr     (req_vaddr),
    .req_store     (req_store),
    .req_mode      (req_mode),
    .req_err_lvl   (req_err_lvl),
    .rsp_valid     (rsp_valid),
    .rsp_seg       (rsp_seg),
    .rsp_mapped    (rsp_mapped),
    .rsp_fault     (rsp_fault),
    .rsp_paddr     (rsp_paddr),
    .tlb_req_valid (tlb_req_valid),
    .tlb_vaddr     (tlb_vaddr)
);

// File: tb/priv_seg_decoder_bench.sv
// Scoreboard bench: the driver pushes expected items, the monitor pops them.
module priv_seg_decoder_bench;

    localparam int VA_W = 32;

    typedef struct packed {
        logic [2:0]  seg;
        logic        mapped;
        logic [1:0]  fault;
        logic [31:0] paddr;
        logic        tlb;
        logic [31:0] tva;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic        req_store = 1'b0;
    logic [1:0]  req_mode = '0;
    logic        req_err_lvl = 1'b0;
    logic        rsp_valid;
    logic [2:0]  rsp_seg;
    logic        rsp_mapped;
    logic [1:0]  rsp_fault;
    logic [31:0] rsp_paddr;
    logic        tlb_req_valid;
    logic [31:0] tlb_vaddr;

    int   n_checks = 0;
    int   n_fail = 0;
    exp_t exp_q[$];
    string tag_q[$];

    always #2 clk = ~clk;

    priv_seg_decoder #(.VA_W(VA_W)) u_priv_seg_decoder (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_store(req_store), .req_mode(req_mode), .req_err_lvl(req_err_lvl),
        .rsp_valid(rsp_valid), .rsp_seg(rsp_seg), .rsp_mapped(rsp_mapped),
        .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr),
        .tlb_req_valid(tlb_req_valid), .tlb_vaddr(tlb_vaddr)
    );

    // Reference model written from the requirements.
    function automatic exp_t model(input logic [31:0] a, input logic [1:0] m,
                                   input logic erl, input logic st, output string tag);
        exp_t e;
        logic kern, sup, ok;
        e = '0;
        kern = (m == 2'b00);
        sup  = (m == 2'b01);
        if (!a[31])                  e.seg = 3'd0;
        else if (a[31:29] == 3'b100) e.seg = 3'd1;
        else if (a[31:29] == 3'b101) e.seg = 3'd2;
        else if (a[31:29] == 3'b110) e.seg = 3'd3;
        else                         e.seg = 3'd4;
        case (e.seg)
            3'd0:    ok = 1'b1;
            3'd3:    ok = kern || sup;
            default: ok = kern;
        endcase
        tag = "R13";
        if (!ok) begin
            e.fault = st ? 2'b10 : 2'b01;
            tag = {tag, (e.seg == 3'd1 || e.seg == 3'd2) ? " R9" :
                        (e.seg == 3'd3) ? " R7" : " R8", " R10"};
        end else begin
            case (e.seg)
                3'd0: begin
                    if (erl) begin e.paddr = a; tag = {tag, " R4"}; end
                    else begin e.mapped = 1'b1; tag = {tag, " R3"}; end
                end
                3'd1: begin e.paddr = a - 32'h8000_0000; tag = {tag, " R5"}; end
                3'd2: begin e.paddr = a - 32'hA000_0000; tag = {tag, " R6"}; end
                3'd3: begin e.mapped = 1'b1; tag = {tag, " R7"}; end
                default: begin e.mapped = 1'b1; tag = {tag, " R8"}; end
            endcase
        end
        if (e.mapped) begin e.tlb = 1'b1; e.tva = a; end
        if (m == 2'b11) tag = {tag, " R11"};
        if (erl && a[31]) tag = {tag, " R12"};
        return e;
    endfunction

    // Driver: one request in the next cycle, expectation queued.
    task automatic drive(input logic [31:0] a, input logic [1:0] m,
                         input logic erl, input logic st);
        string t;
        exp_t e;
        @(negedge clk);
        req_valid = 1'b1; req_vaddr = a; req_mode = m;
        req_err_lvl = erl; req_store = st;
        e = model(a, m, erl, st, t);
        exp_q.push_back(e);
        tag_q.push_back(t);
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0;
        req_vaddr = 32'hDEAD_BEEF;
    endtask

    // Monitor: compare each response against the queue head.
    always @(negedge clk) begin
        if (rst_n) begin
            if (rsp_valid) begin
                n_checks++;
                if (exp_q.size() == 0) begin
                    n_fail++;
                    $display("FAIL R2 unexpected response: rsp_valid=1 expected 0");
                end else begin
                    exp_t e;
                    exp_t got;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    got = '{seg: rsp_seg, mapped: rsp_mapped, fault: rsp_fault,
                            paddr: rsp_paddr, tlb: tlb_req_valid, tva: tlb_vaddr};
                    if (got !== e) begin
                        n_fail++;
                        $display("FAIL %s actual seg=%0d map=%0d flt=%0d pa=%h tlb=%0d tva=%h expected seg=%0d map=%0d flt=%0d pa=%h tlb=%0d tva=%h",
                                 t, got.seg, got.mapped, got.fault, got.paddr, got.tlb, got.tva,
                                 e.seg, e.mapped, e.fault, e.paddr, e.tlb, e.tva);
                    end
                end
            end else if (tlb_req_valid) begin
                n_checks++;
                n_fail++;
                $display("FAIL R2 TLB request without response: actual 1 expected 0");
            end
        end
    end

    task automatic check_quiet(input string t);
        n_checks++;
        if (rsp_valid !== 1'b0 || tlb_req_valid !== 1'b0) begin
            n_fail++;
            $display("FAIL %s actual rsp_valid=%0d tlb_req_valid=%0d expected 0 0",
                     t, rsp_valid, tlb_req_valid);
        end
    endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired: actual running expected done");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    // Stimulus.
    initial begin
        logic [31:0] bnd [11];
        logic [31:0] lfsr;
        bnd = '{32'h0000_0000, 32'h7FFF_FFFF, 32'h8000_0000, 32'h9FFF_FFFF,
                32'hA000_0000, 32'hBFFF_FFFF, 32'hC000_0000, 32'hDFFF_FFFF,
                32'hE000_0000, 32'hFFFF_FFFF, 32'h1234_5678};
        repeat (3) @(negedge clk);
        check_quiet("R1 in reset");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check_quiet("R1 after reset");

        for (int m = 0; m < 4; m++) begin
            for (int i = 0; i < 11; i++) begin
                for (int k = 0; k < 4; k++) begin
                    drive(bnd[i], 2'(m), k[0], k[1]);
                end
            end
            idle();
        end

        lfsr = 32'hACE1_1234;
        for (int n = 0; n < 300; n++) begin
            lfsr = lfsr ^ (lfsr << 13);
            lfsr = lfsr ^ (lfsr >> 17);
            lfsr = lfsr ^ (lfsr << 5);
            drive(lfsr, lfsr[3:2], lfsr[4], lfsr[5]);
            if (lfsr[7:6] == 2'b00) idle();
        end
        idle();
        repeat (4) @(negedge clk);
        n_checks++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL R2 missing responses: actual %0d pending expected 0", exp_q.size());
        end
        check_quiet("R2 idle at end");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule